// File: doc/BRIEF.md
# Granularity-Switched Banked Scratchpad

This block is a byte-addressed scratchpad split into W physical banks, each one byte wide and N/W entries deep. A single request reads or writes W bytes in one clock. A granularity value G, given with each request, sets how the W lanes of the access spread over the address space. The W lanes form W/G groups of G consecutive bytes. Each group starts W+G bytes after the one before it. Every lane of an access therefore lands in a different physical bank, whatever G is, so an access never has a bank conflict.

The intended use is matrix work. Element (i, c) of a W-by-W byte matrix is stored at address i*(W+1)+c, so row i begins in bank i mod W. A request with G=W at address i*(W+1) returns row i as one contiguous line. A request with G=1 at address c gathers column c, one byte from each bank. Both come from the same stored data and take one cycle each.

Top module: `banked_gran_mem`

## Requirements
- R1: For a valid request at base address A with granularity G, lane k (0 to W-1) addresses byte (A + k + floor(k/G)*W) mod N.
- R2: reqGran is read as an unsigned binary G. Only 1, 2, 4 … W are valid. A request with any other value writes nothing, leaves rdData unchanged, and drives errFlag high in the following cycle.
- R3: In a write, lane k is stored only when wrBe[k] is 1. Bytes whose lanes are disabled keep their old contents.
- R4: rdData lane k occupies bits [8k+7:8k] and changes on the clock edge that accepts the request, so it is valid one cycle after the request.
- R5: A write request also returns, on rdData, the contents its lanes held before the write.
- R6: While reqValid is 0, rdData holds its value, errFlag is 0 and nothing is written.
- R7: With the skewed matrix layout, a request with G=W at address i*(W+1) returns row i, with column c on lane c.
- R8: With the skewed matrix layout, a request with G=1 at address c returns column c, with row i on lane i.
- R9: While rst is high and after it is released, rdData is 0 and errFlag is 0 until the first accepted request.
- R10: Lane addresses wrap modulo N past the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | log2(N) | Base byte address |
| reqGran | input | log2(W)+1 | Granularity G as a binary value |
| reqWrite | input | 1 | 1 = write, 0 = read |
| wrData | input | 8*W | Write data, lane k in bits [8k+7:8k] |
| wrBe | input | W | Per-lane write enables |
| rdData | output | 8*W | Registered lane data |
| errFlag | output | 1 | Pulses one cycle after a request with an invalid granularity |

## Verification
The properties assume that rst is held high for at least one clock edge before any request. They also assume that reqGran has a defined value whenever reqValid is high. Because the hold properties compare rdData from one cycle to the next, every input must change only away from the rising edge. The bench drives all inputs on the falling edge and raises reqValid only after reset is released. Random requests always use a valid power-of-two G. Invalid values are sent only in a directed pass, so the error-pulse properties see both polarities.

// File: rtl/banked_gran_mem_pkg.sv
package banked_gran_mem_pkg;
  // Per-cycle command from control to datapath
  typedef struct packed {
    logic capture;  // load the lane register with the gathered bytes
    logic store;    // commit enabled lanes into their banks
  } memStrobes_t;
endpackage

// File: rtl/banked_gran_mem_ctrl.sv
module banked_gran_mem_ctrl
  import banked_gran_mem_pkg::*;
#(
  parameter int W = 8,
  parameter int N = 256
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          reqValid,
  input  logic [$clog2(N)-1:0]          reqAddr,
  input  logic [$clog2(W):0]            reqGran,
  input  logic                          reqWrite,
  output memStrobes_t                   strobes,
  output logic [W-1:0][$clog2(N/W)-1:0] bankRow,
  output logic [W-1:0][$clog2(W)-1:0]   bankLane,
  output logic [W-1:0][$clog2(W)-1:0]   laneBank,
  output logic                          errFlag
);
  localparam int AW = $clog2(N);
  localparam int LW = $clog2(W);
  localparam int GW = LW + 1;
  localparam int RW = $clog2(N / W);
  localparam int SW = (GW > 1) ? $clog2(GW) : 1;

  logic          granOk;
  logic [SW-1:0] gShift;

  // Exactly one bit set, at a position no higher than log2(W)
  always_comb begin
    granOk = (reqGran != '0) && ((reqGran & (reqGran - GW'(1))) == '0)
             && (reqGran <= GW'(W));
    gShift = '0;
    for (int i = 0; i < GW; i++) begin
      if (reqGran[i]) gShift = SW'(i);
    end
  end

  assign strobes.capture = reqValid && granOk;
  assign strobes.store   = reqValid && granOk && reqWrite;

  // Lane k always lands in bank (A + k) mod W; the group offset adds whole lines only
  for (genvar b = 0; b < W; b++) begin : g_bank
    logic [LW-1:0] lane;
    logic [LW-1:0] grp;
    assign lane        = LW'(b) - reqAddr[LW-1:0];
    assign grp         = lane >> gShift;
    assign bankLane[b] = lane;
    assign bankRow[b]  = RW'((AW'(reqAddr) + AW'(lane) + (AW'(grp) << LW)) >> LW);
  end

  for (genvar k = 0; k < W; k++) begin : g_lane
    assign laneBank[k] = reqAddr[LW-1:0] + LW'(k);
  end

  always_ff @(posedge clk) begin
    if (rst) errFlag <= 1'b0;
    else     errFlag <= reqValid && !granOk;
  end
endmodule

// File: rtl/banked_gran_mem_dp.sv
module banked_gran_mem_dp
  import banked_gran_mem_pkg::*;
#(
  parameter int W = 8,
  parameter int N = 256
) (
  input  logic                          clk,
  input  logic                          rst,
  input  memStrobes_t                   strobes,
  input  logic [W-1:0][$clog2(N/W)-1:0] bankRow,
  input  logic [W-1:0][$clog2(W)-1:0]   bankLane,
  input  logic [W-1:0][$clog2(W)-1:0]   laneBank,
  input  logic [W-1:0][7:0]             wrData,
  input  logic [W-1:0]                  wrBe,
  output logic [W-1:0][7:0]             rdData
);
  localparam int DEPTH = N / W;

  logic [W-1:0][7:0] bankOut;
  logic [W-1:0][7:0] laneData;

  for (genvar b = 0; b < W; b++) begin : g_bank
    logic [7:0] cells [DEPTH];
    assign bankOut[b] = cells[bankRow[b]];
    always_ff @(posedge clk) begin
      if (strobes.store && wrBe[bankLane[b]]) cells[bankRow[b]] <= wrData[bankLane[b]];
    end
  end

  // Crossbar from physical bank order back to lane order
  for (genvar k = 0; k < W; k++) begin : g_lane
    assign laneData[k] = bankOut[laneBank[k]];
  end

  // Old contents are captured on the same edge that writes, so a write returns prior data
  always_ff @(posedge clk) begin
    if (rst)                  rdData <= '0;
    else if (strobes.capture) rdData <= laneData;
  end
endmodule

// File: rtl/banked_gran_mem.sv
module banked_gran_mem
  import banked_gran_mem_pkg::*;
#(
  parameter int W = 8,
  parameter int N = 256
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reqValid,
  input  logic [$clog2(N)-1:0]   reqAddr,
  input  logic [$clog2(W):0]     reqGran,
  input  logic                   reqWrite,
  input  logic [8*W-1:0]         wrData,
  input  logic [W-1:0]           wrBe,
  output logic [8*W-1:0]         rdData,
  output logic                   errFlag
);
  memStrobes_t                   strobes;
  logic [W-1:0][$clog2(N/W)-1:0] bankRow;
  logic [W-1:0][$clog2(W)-1:0]   bankLane;
  logic [W-1:0][$clog2(W)-1:0]   laneBank;
  logic [W-1:0][7:0]             rdLanes;

  banked_gran_mem_ctrl #(.W(W), .N(N)) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqGran(reqGran), .reqWrite(reqWrite), .strobes(strobes),
    .bankRow(bankRow), .bankLane(bankLane), .laneBank(laneBank),
    .errFlag(errFlag)
  );

  banked_gran_mem_dp #(.W(W), .N(N)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .bankRow(bankRow),
    .bankLane(bankLane), .laneBank(laneBank), .wrData(wrData),
    .wrBe(wrBe), .rdData(rdLanes)
  );

  assign rdData = rdLanes;
endmodule

// File: rtl/banked_gran_mem_chk.sv
module banked_gran_mem_chk #(
  parameter int W = 8,
  parameter int N = 256
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 reqValid,
  input logic [$clog2(W):0]   reqGran,
  input logic [8*W-1:0]       rdData,
  input logic                 errFlag
);
  logic badGran;
  assign badGran = ($countones(reqGran) != 1) || (int'(reqGran) > W);

  assert_err_on_bad_R2: assert property (@(posedge clk) disable iff (rst)
    (reqValid && badGran) |=> errFlag);

  assert_no_err_on_good_R2: assert property (@(posedge clk) disable iff (rst)
    !(reqValid && badGran) |=> !errFlag);

  assert_hold_on_bad_R2: assert property (@(posedge clk) disable iff (rst)
    (reqValid && badGran) |=> $stable(rdData));

  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> $stable(rdData));
endmodule

bind banked_gran_mem banked_gran_mem_chk #(.W(W), .N(N)) u_chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqGran(reqGran),
  .rdData(rdData), .errFlag(errFlag)
);

// File: tb/test_banked_gran_mem.sv
`timescale 1ns/1ps
module test_banked_gran_mem;
  localparam int W  = 8;
  localparam int N  = 256;
  localparam int AW = $clog2(N);
  localparam int GW = $clog2(W) + 1;
  localparam int LB = 8 * W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [GW-1:0] reqGran = GW'(1);
  logic reqWrite = 1'b0;
  logic [LB-1:0] wrData = '0;
  logic [W-1:0] wrBe = '0;
  logic [LB-1:0] rdData;
  logic errFlag;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;
  logic [7:0] refMem [N];
  logic [7:0] mat [W][W];

  always #5 clk = ~clk;

  banked_gran_mem #(.W(W), .N(N)) i_banked_gran_mem (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqGran(reqGran), .reqWrite(reqWrite), .wrData(wrData),
    .wrBe(wrBe), .rdData(rdData), .errFlag(errFlag)
  );

  function automatic int laneAddr(int base, int g, int k);
    return (base + k + (k / g) * W) % N;
  endfunction

  function automatic logic [LB-1:0] expLine(int base, int g);
    logic [LB-1:0] v;
    for (int k = 0; k < W; k++) v[8*k +: 8] = refMem[laneAddr(base, g, k)];
    return v;
  endfunction

  function automatic bit goodGran(int g);
    return (g >= 1) && (g <= W) && ((g & (g - 1)) == 0);
  endfunction

  task automatic check(string req, logic [LB-1:0] act, logic [LB-1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive on the falling edge; rdData and errFlag are sampled on the next falling edge
  task automatic access(input int base, input int g, input bit wr,
                        input logic [LB-1:0] d, input logic [W-1:0] be,
                        output logic [LB-1:0] expOld);
    expOld = expLine(base, goodGran(g) ? g : 1);
    reqValid = 1'b1; reqAddr = AW'(base); reqGran = GW'(g);
    reqWrite = wr; wrData = d; wrBe = be;
    if (wr && goodGran(g))
      for (int k = 0; k < W; k++)
        if (be[k]) refMem[laneAddr(base, g, k)] = d[8*k +: 8];
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  function automatic logic [LB-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    logic [LB-1:0] e;
    logic [LB-1:0] prev;
    logic [LB-1:0] line;
    void'($urandom(32'h5EED_0042));
    for (int a = 0; a < N; a++) refMem[a] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset values
    check("R9 rdData after reset", rdData, '0);
    check("R9 errFlag after reset", LB'(errFlag), '0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 rdData before first request", rdData, '0);

    // Clear the whole array so all contents are known
    for (int r = 0; r < N / W; r++) access(r * W, W, 1'b1, '0, '1, e);

    // Skewed matrix fill: element (i,c) at i*(W+1)+c, one full-width write per row
    for (int i = 0; i < W; i++) begin
      for (int c = 0; c < W; c++) begin
        mat[i][c] = 8'($urandom());
        line[8*c +: 8] = mat[i][c];
      end
      access(i * (W + 1), W, 1'b1, line, '1, e);
      check("R5 row write returns old data", rdData, e);
    end
    // R7: row reads with G=W
    for (int i = 0; i < W; i++) begin
      for (int c = 0; c < W; c++) line[8*c +: 8] = mat[i][c];
      access(i * (W + 1), W, 1'b0, '0, '0, e);
      check("R7 matrix row", rdData, line);
    end
    // R8: column reads with G=1
    for (int c = 0; c < W; c++) begin
      for (int i = 0; i < W; i++) line[8*i +: 8] = mat[i][c];
      access(c, 1, 1'b0, '0, '0, e);
      check("R8 matrix column", rdData, line);
    end

    // R3: partial byte enables, then read back
    access(40, 2, 1'b1, 64'hA1A2_A3A4_A5A6_A7A8, 8'b1010_0101, e);
    check("R3 R5 masked write old data", rdData, e);
    access(40, 2, 1'b0, '0, '0, e);
    check("R3 masked bytes kept", rdData, e);

    // R10: wrap past the top of the address space
    access(N - 3, W, 1'b1, 64'h1122_3344_5566_7788, '1, e);
    access(N - 3, W, 1'b0, '0, '0, e);
    check("R10 wrap read", rdData, 64'h1122_3344_5566_7788);
    access(0, W, 1'b0, '0, '0, e);
    check("R10 wrapped bytes at base 0", rdData, e);

    // R2: invalid granularities
    access(16, 4, 1'b0, '0, '0, e);
    for (int g = 0; g < (1 << GW); g++) begin
      if (!goodGran(g)) begin
        prev = rdData;
        access(16, g, 1'b1, rnd64(), '1, e);
        check("R2 errFlag on bad granularity", LB'(errFlag), LB'(1));
        check("R2 rdData held on bad granularity", rdData, prev);
      end
    end
    access(16, 1, 1'b0, '0, '0, e);
    check("R2 no write on bad granularity", rdData, e);
    check("R2 errFlag clear on good granularity", LB'(errFlag), '0);

    // R6: idle cycles with write inputs toggling
    prev = rdData;
    reqValid = 1'b0; reqWrite = 1'b1; wrData = '1; wrBe = '1; reqAddr = AW'(16); reqGran = GW'(1);
    repeat (3) @(negedge clk);
    check("R6 rdData held when idle", rdData, prev);
    check("R6 errFlag low when idle", LB'(errFlag), '0);
    access(16, 1, 1'b0, '0, '0, e);
    check("R6 no write when idle", rdData, e);

    // R1 R4 R5: random mix of valid accesses
    for (int n = 0; n < 400; n++) begin
      int g;
      g = 1 << ($urandom() % GW);
      access(int'($urandom() % N), g, bit'($urandom() % 2), rnd64(), W'($urandom()), e);
      check("R1 R4 R5 random access", rdData, e);
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    finished = 1'b1;
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule